// File: doc/BRIEF.md
# Small-Page NAND Read Sequencer

This block is the device side of an 8-bit, small-page NAND bus that serves two chip-selected devices. It decodes command and address cycles from the shared data bus and keeps an independent read context for each device. Each context holds a read mode, an address-cycle count and a linear byte address. Read strobes then stream bytes out of a computed, read-only device memory, and the address advances after each strobe. Programming, erasing, busy timing and ECC are not part of the block.

All bus pins are sampled through a two-flop synchroniser on the system clock. A command or address byte is taken on the rising edge of the write strobe, using the bus values seen while the strobe was low. A byte is driven from the falling edge of the read strobe until its rising edge. Each device's context is a four-state machine:

- `ST_IDLE`: no read is open.
- `ST_RD_LO`: column counted from the start of the page.
- `ST_RD_HI`: column offset by 256.
- `ST_RD_SPARE`: column offset by 512, into the spare bytes.

The transitions are:

- Command 0x00 moves any state to `ST_RD_LO`.
- Command 0x01 moves any state to `ST_RD_HI`.
- Command 0x50 moves any state to `ST_RD_SPARE`.
- Command 0xFF moves any state to `ST_IDLE`.
- Any other byte leaves the state where it is.

Top module: `nand_read_seq`

## Requirements
- R1: After reset `io_oe` is 0, both `rdy` bits are 1 and `proto_err` is 0. Every device address is 0, so the first read returns byte 0 of that device.
- R2: With `cle`=1 and `ale`=0, command byte 0x00, 0x01 or 0x50 selects read state `ST_RD_LO`, `ST_RD_HI` or `ST_RD_SPARE` and clears the address-cycle count. Byte 0xFF returns the device to `ST_IDLE`.
- R3: The first address cycle (`ale`=1, `cle`=0) sets the address to the bus byte. It adds 0x100 in `ST_RD_HI` and 0x200 in `ST_RD_SPARE`.
- R4: The second address cycle adds the byte times 135168 (528×256). The third adds the byte times 528.
- R5: Each read strobe returns the byte at the current address, and the address increments when the strobe rises.
- R6: Memory content of device d:
  - Bytes 0..3 hold ceil(IMG_LENd/16896) in little-endian order.
  - The byte at address 16896+k, for k < IMG_LENd, is k[7:0] XOR k[15:8].
  - Every other byte is 0xFF.
- R7: `ce1_n`=0 selects device 0. Otherwise `ce2_n`=0 selects device 1. With both high, strobes change no state and `io_oe` stays 0.
- R8: While a strobe is low, the selected device's `rdy` bit is 0. With both strobes high it is 1, and `io_oe` falls back to 0.
- R9: A write-strobe cycle with `cle` and `ale` both 0 or both 1 is ignored: it changes neither the address nor `proto_err`.
- R10: `proto_err` becomes 1 and stays 1 until reset on any of these, and the offending cycle leaves the address unchanged:
  - a fourth address cycle;
  - an address cycle in `ST_IDLE`;
  - an unknown command byte.
- R11: Each device keeps its own state and address. Traffic to one device does not disturb the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | Chip enable of device 0, active low |
| ce2_n | input | 1 | Chip enable of device 1, active low |
| cle | input | 1 | Command latch qualifier |
| ale | input | 1 | Address latch qualifier |
| re_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| io_in | input | 8 | Bus byte from the host |
| io_out | output | 8 | Byte returned to the host |
| io_oe | output | 1 | Bus drive enable for `io_out` |
| rdy | output | 2 | Ready line per device |
| proto_err | output | 1 | Sticky protocol error flag |

## Verification
The hardest situation to reach from the ports is showing that one device's context survives while the other is being driven.

The stimulus opens a read on device 0 and stops partway through the stream. It then runs full command, address and read traffic on device 1, plus strobes with neither chip enable low. Device 0 must then resume at exactly the next byte.

The four column and row weights are checked by placing a patterned image behind block 0. With this pattern, every offset yields a distinct byte value. The sticky error is driven by each of its three causes in turn, with a reset between causes.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

    localparam int unsigned PAGE_BYTES      = 528;
    localparam int unsigned PAGES_PER_BLOCK = 32;
    localparam int unsigned BLOCK_BYTES     = PAGE_BYTES * PAGES_PER_BLOCK;
    localparam int unsigned ROW_HI_STRIDE   = PAGE_BYTES * 256;
    localparam int unsigned NDEV            = 2;

    localparam logic [7:0] CMD_GO_IDLE  = 8'hFF;
    localparam logic [7:0] CMD_RD_LO    = 8'h00;
    localparam logic [7:0] CMD_RD_HI    = 8'h01;
    localparam logic [7:0] CMD_RD_SPARE = 8'h50;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_RD_SPARE
    } rd_state_t;

    typedef struct packed {
        logic       ce2_n;
        logic       ce1_n;
        logic       cle;
        logic       ale;
        logic       re_n;
        logic       we_n;
        logic [7:0] io;
    } bus_t;

    // Read-only device content: block count header, patterned image, erased rest
    function automatic logic [7:0] image_byte(input logic [31:0] a, input logic [31:0] img_len);
        logic [31:0] nblk;
        logic [31:0] k;
        logic [31:0] sh;
        nblk = (img_len + BLOCK_BYTES - 1) / BLOCK_BYTES;
        k    = a - BLOCK_BYTES;
        sh   = nblk >> {a[1:0], 3'b000};
        if (a < 32'd4)
            return sh[7:0];
        else if (a >= BLOCK_BYTES && k < img_len)
            return k[7:0] ^ k[15:8];
        else
            return 8'hFF;
    endfunction

endpackage

// File: rtl/nrs_sync.sv
module nrs_sync #(
    parameter int          W   = 8,
    parameter logic [W-1:0] RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST;
            cur  <= RST;
            prev <= RST;
        end else begin
            meta <= d;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/nrs_dev.sv
module nrs_dev
    import nrs_pkg::*;
#(
    parameter int AW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_ev,
    input  logic          adr_ev,
    input  logic          inc_ev,
    input  logic [7:0]    bus_byte,
    output logic [AW-1:0] addr,
    output logic          err_ev
);
    rd_state_t  st, st_n;
    logic [1:0] cyc;
    logic       rd_cmd;
    logic [AW-1:0] col_off;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // next state and protocol check
    always_comb begin
        st_n   = st;
        err_ev = 1'b0;
        rd_cmd = 1'b0;
        if (cmd_ev) begin
            unique case (bus_byte)
                CMD_GO_IDLE:  st_n = ST_IDLE;
                CMD_RD_LO:    begin st_n = ST_RD_LO;    rd_cmd = 1'b1; end
                CMD_RD_HI:    begin st_n = ST_RD_HI;    rd_cmd = 1'b1; end
                CMD_RD_SPARE: begin st_n = ST_RD_SPARE; rd_cmd = 1'b1; end
                default:      err_ev = 1'b1;
            endcase
        end
        if (adr_ev && (st == ST_IDLE || cyc == 2'd3))
            err_ev = 1'b1;
    end

    always_comb begin
        unique case (st)
            ST_RD_HI:    col_off = AW'(32'h100);
            ST_RD_SPARE: col_off = AW'(32'h200);
            default:     col_off = '0;
        endcase
    end

    // address build and read increment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
            cyc  <= 2'd0;
        end else begin
            if (adr_ev && !err_ev) begin
                unique case (cyc)
                    2'd0:    addr <= AW'(32'(bus_byte)) + col_off;
                    2'd1:    addr <= addr + AW'(32'(bus_byte) * ROW_HI_STRIDE);
                    2'd2:    addr <= addr + AW'(32'(bus_byte) * PAGE_BYTES);
                    default: addr <= addr;
                endcase
                cyc <= cyc + 2'd1;
            end else if (inc_ev) begin
                addr <= addr + AW'(1);
            end
            if (rd_cmd) cyc <= 2'd0;
        end
    end

    // R2: spare read command lands in its state with a cleared cycle count
    a_r2_cmd_spare: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ev && bus_byte == CMD_RD_SPARE) |=> (st == ST_RD_SPARE && cyc == 2'd0));
    // R5: a read increment advances the address by one
    a_r5_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_ev && !adr_ev) |=> (addr == $past(addr) + AW'(1)));
    // R10: a fourth address cycle leaves the address alone
    a_r10_fourth_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_ev && cyc == 2'd3 && !inc_ev) |=> $stable(addr));
endmodule

// File: rtl/nand_read_seq.sv
module nand_read_seq
    import nrs_pkg::*;
#(
    parameter int          AW       = 26,
    parameter logic [31:0] IMG_LEN0 = 32'd131072,
    parameter logic [31:0] IMG_LEN1 = 32'd20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce1_n,
    input  logic       ce2_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       re_n,
    input  logic       we_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic [1:0] rdy,
    output logic       proto_err
);
    localparam int BW = $bits(bus_t);
    localparam logic [31:0] IMG_LEN [NDEV] = '{IMG_LEN0, IMG_LEN1};

    bus_t raw, cur, prev;
    logic we_rise, re_fall, re_rise, cmd_cyc, adr_cyc;
    logic [NDEV-1:0] wsel, rsel, err_ev, inc_ev;
    logic [AW-1:0]   dev_addr [NDEV];
    logic [7:0]      dev_byte [NDEV];
    logic            rd_active, rd_dev;
    logic [7:0]      dout;

    assign raw = {ce2_n, ce1_n, cle, ale, re_n, we_n, io_in};

    nrs_sync #(.W(BW), .RST({BW{1'b1}})) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .cur(cur), .prev(prev)
    );

    assign we_rise = cur.we_n & ~prev.we_n;
    assign re_fall = ~cur.re_n & prev.re_n;
    assign re_rise = cur.re_n & ~prev.re_n;
    assign cmd_cyc = we_rise & prev.cle & ~prev.ale;
    assign adr_cyc = we_rise & prev.ale & ~prev.cle;
    assign wsel    = {prev.ce1_n & ~prev.ce2_n, ~prev.ce1_n};
    assign rsel    = {cur.ce1_n & ~cur.ce2_n, ~cur.ce1_n};

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        assign inc_ev[d] = re_rise & rd_active & (rd_dev == 1'(d));
        nrs_dev #(.AW(AW)) u_dev (
            .clk(clk), .rst_n(rst_n),
            .cmd_ev(cmd_cyc & wsel[d]),
            .adr_ev(adr_cyc & wsel[d]),
            .inc_ev(inc_ev[d]),
            .bus_byte(prev.io),
            .addr(dev_addr[d]),
            .err_ev(err_ev[d])
        );
        assign dev_byte[d] = image_byte(32'(dev_addr[d]), IMG_LEN[d]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_active <= 1'b0;
            rd_dev    <= 1'b0;
            dout      <= 8'h00;
            rdy       <= 2'b11;
            proto_err <= 1'b0;
        end else begin
            if (re_fall && rsel != '0) begin
                rd_active <= 1'b1;
                rd_dev    <= rsel[1];
                dout      <= dev_byte[rsel[1]];
            end else if (re_rise) begin
                rd_active <= 1'b0;
            end
            for (int d = 0; d < NDEV; d++)
                if (rsel[d]) rdy[d] <= cur.re_n & cur.we_n;
            if (|err_ev) proto_err <= 1'b1;
        end
    end

    assign io_out = dout;
    assign io_oe  = rd_active;

    // R10: the error flag never clears outside reset
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
    // R8: once the read strobe has settled high the bus is released
    a_r8_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.re_n && prev.re_n) |-> !io_oe);
    // R7: a read strobe with no chip enable never drives the bus
    a_r7_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        (re_fall && cur.ce1_n && cur.ce2_n && !rd_active) |=> !io_oe);
endmodule

// File: tb/test_nand_read_seq.sv
module test_nand_read_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce1_n = 1'b1, ce2_n = 1'b1, cle = 1'b0, ale = 1'b0, re_n = 1'b1, we_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic io_oe, proto_err;
    logic [1:0] rdy;

    int total = 0, bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    logic oe_q = 1'b0;

    always #10 clk = ~clk;

    nand_read_seq i_nand_read_seq (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .cle(cle), .ale(ale),
        .re_n(re_n), .we_n(we_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .rdy(rdy), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel(input int dev);
        ce1_n = (dev == 0) ? 1'b0 : 1'b1;
        ce2_n = (dev == 1) ? 1'b0 : 1'b1;
    endtask

    task automatic wcyc(input int dev, input bit c, input bit a, input logic [7:0] v);
        sel(dev); cle = c; ale = a; io_in = v;
        ticks(2); we_n = 1'b0;
        ticks(4); we_n = 1'b1;
        ticks(4); cle = 1'b0; ale = 1'b0; sel(2);
    endtask

    task automatic cmd(input int dev, input logic [7:0] v);
        wcyc(dev, 1'b1, 1'b0, v);
    endtask

    task automatic adr(input int dev, input logic [7:0] v);
        wcyc(dev, 1'b0, 1'b1, v);
    endtask

    task automatic rd(input int dev, input logic [7:0] e, input string tag);
        sel(dev); ticks(2);
        exp_q.push_back(e); tag_q.push_back(tag);
        re_n = 1'b0; ticks(4);
        chk(rdy[dev] == 1'b0, "R8 rdy low during strobe", rdy[dev], 0);
        re_n = 1'b1; ticks(4);
        chk(rdy[dev] == 1'b1 && io_oe == 1'b0, "R8 rdy high and bus released", {rdy[dev], io_oe}, 2);
        sel(2);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; ticks(3); rst_n = 1'b1; ticks(2);
    endtask

    // scoreboard monitor: compares each newly driven byte against the queue
    always @(negedge clk) begin
        if (io_oe && !oe_q) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected bus drive", io_out, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(io_out == e, t, io_out, e);
            end
        end
        oe_q = io_oe;
    end

    initial begin
        ticks(200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        ticks(3); rst_n = 1'b1; ticks(2);
        chk(io_oe == 1'b0, "R1 oe after reset", io_oe, 0);
        chk(rdy == 2'b11, "R1 rdy after reset", rdy, 3);
        chk(proto_err == 1'b0, "R1 err after reset", proto_err, 0);

        rd(0, 8'h08, "R1 R6 count byte 0");
        rd(0, 8'h00, "R5 R6 count byte 1");

        cmd(0, 8'h00); adr(0, 8'd5); adr(0, 8'd0); adr(0, 8'd32);
        rd(0, 8'h05, "R3 R5 mode lo col 5");
        rd(0, 8'h06, "R5 increment");

        rd(1, 8'h02, "R7 R11 dev1 count");
        cmd(1, 8'h00); adr(1, 8'd3); adr(1, 8'd0); adr(1, 8'd0);
        rd(1, 8'h00, "R6 dev1 count msb");
        rd(1, 8'hFF, "R6 erased header");

        rd(0, 8'h07, "R11 dev0 resumes");

        // no chip enable: commands and strobes must do nothing
        cmd(2, 8'h50); adr(2, 8'd9);
        sel(2); ticks(2); re_n = 1'b0; ticks(4);
        chk(io_oe == 1'b0, "R7 no drive without select", io_oe, 0);
        re_n = 1'b1; ticks(4);
        rd(0, 8'h08, "R7 state untouched");

        wcyc(0, 1'b0, 1'b0, 8'h50); wcyc(0, 1'b1, 1'b1, 8'h50);
        chk(proto_err == 1'b0, "R9 no error on data cycle", proto_err, 0);
        rd(0, 8'h09, "R9 address untouched");

        cmd(0, 8'h01); adr(0, 8'd5); adr(0, 8'd0); adr(0, 8'd32);
        rd(0, 8'h04, "R3 mode hi");
        rd(0, 8'h07, "R3 mode hi next");
        cmd(0, 8'h50); adr(0, 8'd5); adr(0, 8'd0); adr(0, 8'd32);
        rd(0, 8'h07, "R3 mode spare");

        cmd(0, 8'h00); adr(0, 8'd3); adr(0, 8'd1); adr(0, 8'd0);
        rd(0, 8'hCD, "R4 second cycle weight");
        rd(0, 8'hCA, "R4 second cycle next");
        cmd(0, 8'h00); adr(0, 8'd0); adr(0, 8'd0); adr(0, 8'd33);
        rd(0, 8'h12, "R4 third cycle weight");
        cmd(0, 8'h00); adr(0, 8'd0); adr(0, 8'd2); adr(0, 8'd0);
        rd(0, 8'hFF, "R6 beyond image");

        cmd(0, 8'h00); adr(0, 8'd9); adr(0, 8'd1);
        cmd(0, 8'h00); adr(0, 8'd7); adr(0, 8'd0); adr(0, 8'd32);
        chk(proto_err == 1'b0, "R2 command clears cycle count", proto_err, 0);
        rd(0, 8'h07, "R2 restarted address");

        adr(0, 8'd1);
        chk(proto_err == 1'b1, "R10 fourth address cycle", proto_err, 1);
        rd(0, 8'h08, "R10 address kept");
        cmd(0, 8'h00);
        chk(proto_err == 1'b1, "R10 sticky", proto_err, 1);

        do_reset;
        chk(proto_err == 1'b0, "R1 reset clears error", proto_err, 0);
        cmd(0, 8'hFF); adr(0, 8'd0);
        chk(proto_err == 1'b1, "R10 R2 address while idle", proto_err, 1);

        do_reset;
        cmd(1, 8'h33);
        chk(proto_err == 1'b1, "R10 unknown command", proto_err, 1);

        ticks(4);
        chk(exp_q.size() == 0, "R5 all reads observed", exp_q.size(), 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule